// File: doc/BRIEF.md
# Redundant Replica State Resynchronization Controller

This block holds three copies of the same bank of state registers. In normal operation the copies run in lockstep, and a bitwise majority voter produces the read result. Workload writes go to all three copies at once. When a copy has been reconfigured after a fault, its register contents can no longer be trusted. A one-cycle `repaired` pulse names that copy.

After the pulse, the named copy is taken out of the vote and the block requests a token from a central controller. Once the token is granted, the block copies the bank one word per cycle, in ascending address order, from a healthy copy into the repaired one. The healthy copy is the lowest-indexed copy that is neither the repaired one nor flagged faulty.

The healthy copies keep accepting writes for the whole sequence. A write that lands on a word already copied, or on the word being copied in that cycle, is forwarded to the repaired copy in the same cycle. Words that have not been copied yet stay frozen in the repaired copy. When the last word is done, a one-cycle release phase signals completion, and the repaired copy then rejoins the vote with an image identical to its source. An input that flips bits in one chosen copy stands in for radiation upsets.

Top module: `tmr_resync_ctrl`

## Requirements
- R1: During reset and right after it, every word of all three copies reads zero, `vote_mask` is 3'b111, and `tok_req` and `sync_done` are 0.
- R2: With no sync in progress, a write (`wr_en`, `wr_addr`, `wr_data`) updates the addressed word in all three copies at the next clock edge. A word that is not written holds its value.
- R3: When all three copies vote (`vote_mask` = 3'b111), `rd_voted` is the bitwise majority of the three copies' word at `rd_addr`. A corruption confined to one copy is therefore masked.
- R4: A `repaired` pulse with `repaired_id` d in {0,1,2}, accepted while idle, clears bit d of `vote_mask` and raises `tok_req` from the next cycle on. `tok_req` stays high until `tok_grant` is sampled high. At least two bits of `vote_mask` are always set.
- R5: The source copy is the lowest index that is not d and whose bit in `faulty` is 0, sampled when the pulse is accepted. While a copy is excluded, `rd_voted` equals the source copy's word.
- R6: The copy phase starts at the edge where `tok_grant` is high. It lasts exactly NREG cycles and transfers word 0 up to word NREG-1, one per cycle. During this phase, the repaired copy's words that have not been copied yet do not change.
- R7: A write during the copy phase reaches the repaired copy in the same cycle if its address is already copied or is the word being copied. After release, the repaired copy equals its source word for word.
- R8: After the last word, `sync_done` is high for exactly one cycle with bit d of `vote_mask` still clear. In the following cycle `vote_mask` is 3'b111 again.
- R9: A `repaired` pulse is ignored when a sync is already in progress, when `repaired_id` is 3, or when no eligible source exists.
- R10: The healthy copies accept writes at every address throughout the sync, with the same timing as in R2.
- R11: An upset (`upset_en`, `upset_rep` selecting copy 0..2, `upset_addr`, `upset_mask`) XORs the mask into that one copy's word at the next edge. This happens after any write or copy to the same word in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Workload write strobe |
| wr_addr | input | AW | Workload write word address |
| wr_data | input | W | Workload write data |
| upset_en | input | 1 | Inject a bit-flip into one copy |
| upset_rep | input | 2 | Copy index that receives the flip |
| upset_addr | input | AW | Word that receives the flip |
| upset_mask | input | W | Bits to invert |
| faulty | input | 3 | Copies known to be faulty, one bit per copy |
| repaired | input | 1 | One-cycle pulse: a copy has just been reconfigured |
| repaired_id | input | 2 | Index of the reconfigured copy |
| tok_grant | input | 1 | Token from the central controller |
| rd_addr | input | AW | Read word address |
| rd_voted | output | W | Voted read data |
| rd_rep | output | 3*W | Per-copy read data, copy r at bits r*W +: W |
| vote_mask | output | 3 | Copies currently taking part in the vote |
| tok_req | output | 1 | Waiting for the token |
| sync_done | output | 1 | One-cycle release pulse at the end of the copy |

## Verification
The bench drives writes in the same cycle the copy pointer is at, before it, and after it. A design without forwarding would leave a stale word in the repaired copy. A design that forwards every write would let the repaired copy change a word ahead of the pointer. Two copies are corrupted in the same bit while one is excluded: a voter that keeps majority voting during exclusion returns the flipped bit. A known-faulty low-index copy is corrupted before a sync, so choosing the wrong source would spread the corruption into the repaired copy. Stray pulses during a sync, and pulses with no eligible source, are checked to leave `vote_mask` and `tok_req` untouched.

// File: rtl/tmr_sync_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the replica resynchronization block.
// Assumes exactly three replicas; the count is fixed by the voter.
package tmr_sync_pkg;
    localparam int NREP = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_GRANT   = 2'd1,
        ST_COPY    = 2'd2,
        ST_RELEASE = 2'd3
    } sync_state_e;
endpackage

// File: rtl/tmr_replica_bank.sv
`timescale 1ns/1ps
// One replica's bank of state words.
// Per word, priority is: workload write, then copy-path write, then upset XOR on top.
// Assumes at most one write, one copy and one upset per cycle.
module tmr_replica_bank #(
    parameter int NREG = 8,
    parameter int W    = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [W-1:0]    wr_data,
    input  logic            cp_en,
    input  logic [AW-1:0]   cp_addr,
    input  logic [W-1:0]    cp_data,
    input  logic            up_en,
    input  logic [AW-1:0]   up_addr,
    input  logic [W-1:0]    up_mask,
    output logic [NREG*W-1:0] image
);
    for (genvar g = 0; g < NREG; g++) begin : g_word
        logic [W-1:0] q, d;

        // Next value of this word from the three update sources.
        always_comb begin
            d = q;
            if (wr_en && wr_addr == AW'(g)) d = wr_data;
            if (cp_en && cp_addr == AW'(g)) d = cp_data;
            if (up_en && up_addr == AW'(g)) d = d ^ up_mask;
        end

        // Word storage with synchronous reset to zero.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= d;
        end

        assign image[g*W +: W] = q;
    end

    assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !cp_en && !up_en) |=> $stable(image));
endmodule

// File: rtl/tmr_sync_fsm.sv
`timescale 1ns/1ps
// Token and copy sequencer: IDLE -> GRANT -> COPY(0..NREG-1) -> RELEASE -> IDLE.
// Picks the source replica when a repair pulse is accepted.
// Assumes repaired is a single-cycle pulse.
module tmr_sync_fsm
    import tmr_sync_pkg::*;
#(
    parameter int NREG = 8,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          repaired,
    input  logic [1:0]    repaired_id,
    input  logic [2:0]    faulty,
    input  logic          tok_grant,
    output logic [1:0]    dest_id,
    output logic [1:0]    src_id,
    output logic          cp_en,
    output logic [AW-1:0] cp_addr,
    output logic [2:0]    vote_mask,
    output logic          tok_req,
    output logic          sync_done
);
    sync_state_e   state;
    logic [AW-1:0] idx;
    logic          src_ok;
    logic [1:0]    src_c;
    logic          accept;

    // Lowest-indexed replica that is neither faulty nor the one being repaired.
    always_comb begin
        src_ok = 1'b0;
        src_c  = 2'd0;
        for (int i = NREP - 1; i >= 0; i--) begin
            if (!faulty[i] && 2'(i) != repaired_id) begin
                src_ok = 1'b1;
                src_c  = 2'(i);
            end
        end
    end

    // A pulse counts only while idle, for a real replica, with a usable source.
    assign accept = repaired && (state == ST_IDLE) && (repaired_id != 2'd3) && src_ok;

    // Sequencer state, copy pointer and latched replica indices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            dest_id <= 2'd0;
            src_id  <= 2'd0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    state   <= ST_GRANT;
                    dest_id <= repaired_id;
                    src_id  <= src_c;
                end
                ST_GRANT: if (tok_grant) begin
                    state <= ST_COPY;
                    idx   <= '0;
                end
                ST_COPY: begin
                    if (idx == AW'(NREG - 1)) state <= ST_RELEASE;
                    else                      idx   <= idx + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cp_en     = (state == ST_COPY);
    assign cp_addr   = idx;
    assign tok_req   = (state == ST_GRANT);
    assign sync_done = (state == ST_RELEASE);
    assign vote_mask = (state == ST_IDLE) ? 3'b111 : ~(3'b001 << dest_id);

    assert_req_from_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tok_req) |-> $past(repaired));
    assert_copy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_done |-> ($past(cp_en) && $past(cp_addr) == AW'(NREG - 1)));
    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_en && $past(cp_en)) |-> (cp_addr == $past(cp_addr) + 1'b1));
endmodule

// File: rtl/tmr_voter.sv
`timescale 1ns/1ps
// Read voter: bitwise majority when all three replicas vote,
// otherwise passes the chosen source replica through.
// Assumes that when a replica is excluded, src_id names a voting one.
module tmr_voter #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic [2:0]   mask,
    input  logic [1:0]   src_id,
    output logic [W-1:0] y
);
    // Select majority or single-source output.
    always_comb begin
        if (mask == 3'b111) y = (a & b) | (a & c) | (b & c);
        else begin
            case (src_id)
                2'd1:    y = b;
                2'd2:    y = c;
                default: y = a;
            endcase
        end
    end
endmodule

// File: rtl/tmr_resync_ctrl.sv
`timescale 1ns/1ps
// Top: three replica banks, the sync sequencer and the read voter.
// During the copy phase the destination takes a write only for words
// already copied; the current word arrives via the copy path with any
// same-cycle write merged in. Assumes faulty is stable around the repair pulse.
module tmr_resync_ctrl
    import tmr_sync_pkg::*;
#(
    parameter int NREG = 8,
    parameter int W    = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [W-1:0]    wr_data,
    input  logic            upset_en,
    input  logic [1:0]      upset_rep,
    input  logic [AW-1:0]   upset_addr,
    input  logic [W-1:0]    upset_mask,
    input  logic [2:0]      faulty,
    input  logic            repaired,
    input  logic [1:0]      repaired_id,
    input  logic            tok_grant,
    input  logic [AW-1:0]   rd_addr,
    output logic [W-1:0]    rd_voted,
    output logic [3*W-1:0]  rd_rep,
    output logic [2:0]      vote_mask,
    output logic            tok_req,
    output logic            sync_done
);
    logic [1:0]      dest_id, src_id;
    logic            cp_en;
    logic [AW-1:0]   cp_addr;
    logic [W-1:0]    cp_data;
    logic [NREG*W-1:0] img [NREP];
    logic [NREG*W-1:0] src_img, dst_img;

    tmr_sync_fsm #(.NREG(NREG)) i_fsm (
        .clk(clk), .rst_n(rst_n), .repaired(repaired), .repaired_id(repaired_id),
        .faulty(faulty), .tok_grant(tok_grant), .dest_id(dest_id), .src_id(src_id),
        .cp_en(cp_en), .cp_addr(cp_addr), .vote_mask(vote_mask),
        .tok_req(tok_req), .sync_done(sync_done)
    );

    // Source and destination bank images.
    always_comb begin
        case (src_id)
            2'd1:    src_img = img[1];
            2'd2:    src_img = img[2];
            default: src_img = img[0];
        endcase
        case (dest_id)
            2'd1:    dst_img = img[1];
            2'd2:    dst_img = img[2];
            default: dst_img = img[0];
        endcase
    end

    // Copy word: the source's next value, so a same-cycle write is not lost.
    assign cp_data = (wr_en && wr_addr == cp_addr) ? wr_data
                                                   : src_img[int'(cp_addr)*W +: W];

    for (genvar r = 0; r < NREP; r++) begin : g_rep
        logic is_dst;
        logic r_wr_en;

        assign is_dst  = cp_en && (dest_id == 2'(r));
        // Destination words at or ahead of the pointer stay frozen.
        assign r_wr_en = wr_en && !(is_dst && wr_addr >= cp_addr);

        tmr_replica_bank #(.NREG(NREG), .W(W)) i_bank (
            .clk(clk), .rst_n(rst_n),
            .wr_en(r_wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
            .cp_en(is_dst), .cp_addr(cp_addr), .cp_data(cp_data),
            .up_en(upset_en && upset_rep == 2'(r)), .up_addr(upset_addr),
            .up_mask(upset_mask), .image(img[r])
        );

        assign rd_rep[r*W +: W] = img[r][int'(rd_addr)*W +: W];
    end

    tmr_voter #(.W(W)) i_voter (
        .a(rd_rep[0 +: W]), .b(rd_rep[W +: W]), .c(rd_rep[2*W +: W]),
        .mask(vote_mask), .src_id(src_id), .y(rd_voted)
    );

    assert_release_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_done |-> (dst_img == src_img));
    assert_two_voters_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vote_mask) >= 2);
    assert_src_ne_dst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cp_en |-> (src_id != dest_id));
endmodule

// File: tb/test_tmr_resync_ctrl.sv
`timescale 1ns/1ps
// Directed bench for tmr_resync_ctrl: one task per scenario.
module test_tmr_resync_ctrl;
    localparam int NREG = 8;
    localparam int W    = 16;
    localparam int AW   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic upset_en = 1'b0;
    logic [1:0] upset_rep = '0;
    logic [AW-1:0] upset_addr = '0;
    logic [W-1:0] upset_mask = '0;
    logic [2:0] faulty = '0;
    logic repaired = 1'b0;
    logic [1:0] repaired_id = '0;
    logic tok_grant = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [W-1:0] rd_voted;
    logic [3*W-1:0] rd_rep;
    logic [2:0] vote_mask;
    logic tok_req, sync_done;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [W-1:0] m [NREG];

    always #4 clk = ~clk;

    tmr_resync_ctrl #(.NREG(NREG), .W(W)) i_tmr_resync_ctrl (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Read one word and compare the three copies and the voted value.
    task automatic rd_chk(input string req, input int a, input logic [W-1:0] e0,
                          input logic [W-1:0] e1, input logic [W-1:0] e2,
                          input logic [W-1:0] ev);
        rd_addr = AW'(a);
        #1;
        chk({req, " copy0"}, 32'(rd_rep[0 +: W]), 32'(e0));
        chk({req, " copy1"}, 32'(rd_rep[W +: W]), 32'(e1));
        chk({req, " copy2"}, 32'(rd_rep[2*W +: W]), 32'(e2));
        chk({req, " voted"}, 32'(rd_voted), 32'(ev));
    endtask

    task automatic wr(input int a, input logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        step();
        wr_en = 1'b0;
        m[a] = d;
    endtask

    task automatic upset(input int r, input int a, input logic [W-1:0] mk);
        upset_en = 1'b1; upset_rep = 2'(r); upset_addr = AW'(a); upset_mask = mk;
        step();
        upset_en = 1'b0;
    endtask

    task automatic pulse(input int id);
        repaired = 1'b1; repaired_id = 2'(id);
        step();
        repaired = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 vote_mask", 32'(vote_mask), 32'h7);
        chk("R1 tok_req", 32'(tok_req), 32'h0);
        chk("R1 sync_done", 32'(sync_done), 32'h0);
        for (int a = 0; a < NREG; a++) begin
            m[a] = '0;
            rd_chk("R1 zero", a, 0, 0, 0, 0);
        end
    endtask

    task automatic t_lockstep();
        for (int a = 0; a < NREG; a++) wr(a, W'(16'h0100 + a * 16'h0111));
        for (int a = 0; a < NREG; a++) rd_chk("R2 lockstep", a, m[a], m[a], m[a], m[a]);
    endtask

    task automatic t_majority();
        upset(2, 3, 16'hFFFF);
        rd_chk("R3/R11 single upset masked", 3, m[3], m[3], m[3] ^ 16'hFFFF, m[3]);
    endtask

    // Repair copy 1 from copy 0, with writes before, at and after the pointer.
    task automatic t_sync_forward();
        logic [W-1:0] old7;
        faulty = 3'b010;
        pulse(1);
        chk("R4 mask excl", 32'(vote_mask), 32'h5);
        chk("R4 tok_req", 32'(tok_req), 32'h1);
        upset(1, 5, 16'h0001);
        upset(2, 5, 16'h0001);
        chk("R4 tok_req held", 32'(tok_req), 32'h1);
        rd_chk("R5 voted from source", 5, m[5], m[5] ^ 1, m[5] ^ 1, m[5]);
        rd_chk("R5 source word3", 3, m[3], m[3], m[3] ^ 16'hFFFF, m[3]);
        old7 = m[7];
        tok_grant = 1'b1;
        step();
        tok_grant = 1'b0;
        chk("R4 tok_req drop", 32'(tok_req), 32'h0);
        wr(7, 16'hA7A7);
        rd_chk("R6/R10 ahead frozen", 7, 16'hA7A7, old7, 16'hA7A7, 16'hA7A7);
        wr(0, 16'h0B0B);
        wr(2, 16'h2C2C);
        for (int k = 3; k < NREG - 1; k++) step();
        chk("R8 not yet done", 32'(sync_done), 32'h0);
        step();
        chk("R8 sync_done", 32'(sync_done), 32'h1);
        chk("R8 mask during release", 32'(vote_mask), 32'h5);
        step();
        chk("R8 sync_done low", 32'(sync_done), 32'h0);
        chk("R8 mask restored", 32'(vote_mask), 32'h7);
        for (int a = 0; a < NREG; a++) begin
            rd_addr = AW'(a);
            #1;
            chk("R7 dest copy1", 32'(rd_rep[W +: W]), 32'(m[a]));
            chk("R7 source copy0", 32'(rd_rep[0 +: W]), 32'(m[a]));
        end
        faulty = 3'b000;
    endtask

    // Repair copy 2; copy 0 is marked faulty, so copy 1 must be the source.
    task automatic t_sync_source_pick();
        int a;
        faulty = 3'b001;
        pulse(2);
        chk("R4 mask excl2", 32'(vote_mask), 32'h3);
        upset(0, 6, 16'h00FF);
        pulse(0);
        chk("R9 busy pulse ignored", 32'(vote_mask), 32'h3);
        chk("R9 busy tok_req", 32'(tok_req), 32'h1);
        rd_addr = AW'(6);
        #1;
        chk("R5 voted copy1", 32'(rd_voted), 32'(m[6]));
        tok_grant = 1'b1;
        step();
        tok_grant = 1'b0;
        for (int k = 0; k < NREG; k++) begin
            a = (k == 7) ? 3 : (k * 5 + 3) % 8;
            wr(a, W'(16'h1000 + k));
        end
        chk("R8 sync_done2", 32'(sync_done), 32'h1);
        step();
        chk("R8 mask restored2", 32'(vote_mask), 32'h7);
        for (int b = 0; b < NREG; b++) begin
            rd_chk("R7 all equal", b, (b == 6) ? (m[b] ^ 16'h00FF) : m[b], m[b], m[b], m[b]);
        end
        faulty = 3'b000;
    endtask

    task automatic t_ignored();
        faulty = 3'b011;
        pulse(2);
        chk("R9 no source mask", 32'(vote_mask), 32'h7);
        chk("R9 no source tok", 32'(tok_req), 32'h0);
        faulty = 3'b000;
        pulse(3);
        chk("R9 id3 mask", 32'(vote_mask), 32'h7);
        chk("R9 id3 tok", 32'(tok_req), 32'h0);
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_lockstep();
        t_majority();
        t_sync_forward();
        t_sync_source_pick();
        t_ignored();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule